// File: doc/BRIEF.md
# Falling-Edge Pin Interrupt and Vector Sequencer

This block sits next to a core whose instruction cycle is split into four clock phases. It watches one external pin for a falling edge and records each such edge in a pending flag. It then combines that flag with a per-source enable and a global enable, and drives the core into the interrupt vector. The enable bits are written by software through simple write strobes. The pin is honoured only while the core runs from its internal oscillator.

Each instruction cycle is marked by a single-clock strobe for its first phase. The block samples the pending request only on that strobe. When it takes an interrupt, it lets the current instruction finish. It then asks the core for two dummy cycles and requests the vector fetch at `VEC_ADDR` and at `VEC_ADDR+1`. The global enable is cleared at the moment the interrupt is taken. The return address is latched and offered for pushing during the first dummy cycle. While the core sleeps, a flagged and locally enabled edge raises a wake request. The global enable then decides whether the core vectors once it is awake.

Top module: `pin_irq_seq`

## Requirements
- R1: While `rst_n` is low and on the first clock after its release, `flag_o`, `src_en_o`, `gie_o`, `wake_o`, `dummy_o`, `vec_fetch_o` and `push_o` are 0.
- R2: A high-to-low change on `pin_i` with `osc_int_mode_i` high sets `flag_o` on the third rising clock after the change, through a two-flop synchronizer and an edge register. A low-to-high change never sets it.
- R3: While `osc_int_mode_i` is low, edges on `pin_i` leave `flag_o` unchanged.
- R4: `flag_o` stays 1 until a clock with `flag_clr_i` high and then reads 0 from that clock on. If a detected falling edge lands in the same clock as the clear, `flag_o` stays 1.
- R5: With `src_en_o` at 0, an edge still sets `flag_o`, but `dummy_o`, `vec_fetch_o` and `wake_o` stay 0 and `gie_o` is unchanged.
- R6: The request is evaluated only on clocks where `phase_q1_i` is 1. A flag that is set between strobes is acted on at the next strobe, and `gie_o` keeps its value until then.
- R7: An instruction cycle runs from one strobe to the next. After the strobe that takes the interrupt comes one finishing cycle with all controls low. Two cycles with `dummy_o` high follow. Then comes one cycle with `vec_fetch_o` high and `fetch_addr_o` = `VEC_ADDR` (default 4), then one cycle with `vec_fetch_o` high and `fetch_addr_o` = `VEC_ADDR+1`. The timing is the same whether `two_word_i` is 0 or 1.
- R8: While `sleep_i` is 1 and both `flag_o` and `src_en_o` are 1, `wake_o` becomes 1 at the next strobe, whatever `gie_o` holds. No vector sequence starts while `sleep_i` is 1, and `wake_o` returns to 0 at the first strobe that sees `sleep_i` low. With `src_en_o` at 0, `wake_o` stays 0.
- R9: After a wake-up, the first strobe that sees `sleep_i` low starts the R7 sequence if `gie_o` is 1. If `gie_o` is 0, the controls stay low.
- R10: On the clock that takes the interrupt, `gie_o` becomes 0 and `ret_addr_o` becomes `pc_i`+1 when `two_word_i` is 0, or `pc_i`+2 when it is 1. `push_o` is 1 throughout the first dummy cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw external interrupt pin |
| osc_int_mode_i | input | 1 | High when the internal oscillator mode is active; enables the pin |
| phase_q1_i | input | 1 | One-clock strobe marking phase Q1 of each instruction cycle |
| flag_clr_i | input | 1 | Software clear of the pending flag |
| src_en_we_i | input | 1 | Write strobe for the per-source enable |
| src_en_wd_i | input | 1 | Value written to the per-source enable |
| gie_we_i | input | 1 | Write strobe for the global enable |
| gie_wd_i | input | 1 | Value written to the global enable |
| sleep_i | input | 1 | Core is in its sleep state |
| two_word_i | input | 1 | Instruction in progress occupies two words |
| pc_i | input | ADDR_W | Address of the instruction in progress |
| wake_o | output | 1 | Wake request to the sleeping core |
| dummy_o | output | 1 | Current instruction cycle is a dummy cycle |
| vec_fetch_o | output | 1 | Core must fetch from `fetch_addr_o` |
| fetch_addr_o | output | ADDR_W | Vector fetch address |
| push_o | output | 1 | Push `ret_addr_o` onto the return stack |
| ret_addr_o | output | ADDR_W | Return address of the interrupted flow |
| flag_o | output | 1 | Pending flag |
| src_en_o | output | 1 | Per-source enable bit |
| gie_o | output | 1 | Global enable bit |

## Verification
A falling pin edge reaches `flag_o` on the third clock after the pin change. The take happens at the first strobe clock after the flag is set. Relative to that take clock, `gie_o` and `ret_addr_o` change at once and `dummy_o` with `push_o` rises four clocks later. `vec_fetch_o` with `fetch_addr_o`=4 follows at twelve clocks, address 5 at sixteen, and idle at twenty. `wake_o` follows at the first strobe after the flag. The bench derives each of these clock numbers from the clock in which it drives a stimulus. It places edges in different positions relative to the strobe so that both the three-cycle and four-cycle latency occur. The scoreboard compares each expected value only in its due clock and treats an item left past its clock as a mismatch.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // One state per instruction cycle of the vectoring sequence.
  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_FINISH = 3'd1,
    SEQ_DUMMY1 = 3'd2,
    SEQ_DUMMY2 = 3'd3,
    SEQ_VECT   = 3'd4,
    SEQ_FOLLOW = 3'd5
  } seq_state_t;

  localparam int unsigned DEF_ADDR_W      = 13;
  localparam int unsigned DEF_VEC_ADDR    = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic gate_i,
  output logic fall_o
);

  // STAGES synchronizer flops followed by one history flop.
  localparam int unsigned CHAIN_LEN = STAGES + 1;

  logic [CHAIN_LEN-1:0] chain_q;
  logic [CHAIN_LEN-1:0] chain_d;

  always_comb begin
    chain_d[0] = pin_i;
  end

  generate
    for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_shift
      always_comb begin
        chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // Old value high, newest synchronized value low: a falling edge.
  always_comb begin
    fall_o = gate_i & chain_q[CHAIN_LEN-1] & ~chain_q[CHAIN_LEN-2];
  end

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic clr_i,
  input  logic en_we_i,
  input  logic en_wd_i,
  input  logic gie_we_i,
  input  logic gie_wd_i,
  input  logic take_i,
  output logic flag_o,
  output logic en_o,
  output logic gie_o
);

  logic flag_q, flag_d, flag_ce;
  logic en_q,   en_d,   en_ce;
  logic gie_q,  gie_d,  gie_ce;

  always_comb begin
    // A new edge overrides a clear arriving in the same clock.
    flag_ce = fall_i | clr_i;
    flag_d  = fall_i | (flag_q & ~clr_i);

    en_ce   = en_we_i;
    en_d    = en_wd_i;

    // Hardware clear on interrupt entry beats a software write.
    gie_ce  = take_i | gie_we_i;
    gie_d   = take_i ? 1'b0 : gie_wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      gie_q  <= 1'b0;
    end else begin
      if (flag_ce) flag_q <= flag_d;
      if (en_ce)   en_q   <= en_d;
      if (gie_ce)  gie_q  <= gie_d;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign gie_o  = gie_q;

endmodule

// File: rtl/irq_vector_fsm.sv
module irq_vector_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned VEC_ADDR = DEF_VEC_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q1_i,
  input  logic              sleep_i,
  input  logic              flag_i,
  input  logic              en_i,
  input  logic              gie_i,
  input  logic              two_word_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              take_o,
  output logic              wake_o,
  output logic              dummy_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] ret_addr_o
);

  localparam logic [ADDR_W-1:0] VEC0 = ADDR_W'(VEC_ADDR);
  localparam logic [ADDR_W-1:0] VEC1 = ADDR_W'(VEC_ADDR + 1);

  seq_state_t        state_q, state_d;
  logic              wake_q, wake_d;
  logic [ADDR_W-1:0] ret_q, ret_d;
  logic              pending;
  logic              take;

  // Next-state logic; everything steps only on the Q1 strobe.
  always_comb begin
    pending = flag_i & en_i;
    take    = q1_i & (state_q == SEQ_IDLE) & ~sleep_i & pending & gie_i;
    wake_d  = sleep_i & pending;
    ret_d   = pc_i + (two_word_i ? ADDR_W'(2) : ADDR_W'(1));

    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (take) state_d = SEQ_FINISH;
      SEQ_FINISH: state_d = SEQ_DUMMY1;
      SEQ_DUMMY1: state_d = SEQ_DUMMY2;
      SEQ_DUMMY2: state_d = SEQ_VECT;
      SEQ_VECT:   state_d = SEQ_FOLLOW;
      SEQ_FOLLOW: state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      wake_q  <= 1'b0;
      ret_q   <= '0;
    end else begin
      if (q1_i) state_q <= state_d;
      if (q1_i) wake_q  <= wake_d;
      if (take) ret_q   <= ret_d;
    end
  end

  // Outputs decoded from the state register.
  always_comb begin
    dummy_o      = (state_q == SEQ_DUMMY1) | (state_q == SEQ_DUMMY2);
    push_o       = (state_q == SEQ_DUMMY1);
    vec_fetch_o  = (state_q == SEQ_VECT) | (state_q == SEQ_FOLLOW);
    fetch_addr_o = (state_q == SEQ_VECT)   ? VEC0 :
                   (state_q == SEQ_FOLLOW) ? VEC1 : '0;
  end

  assign take_o     = take;
  assign wake_o     = wake_q;
  assign ret_addr_o = ret_q;

endmodule

// File: rtl/pin_irq_seq.sv
module pin_irq_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = DEF_ADDR_W,
  parameter int unsigned VEC_ADDR    = DEF_VEC_ADDR,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              osc_int_mode_i,
  input  logic              phase_q1_i,
  input  logic              flag_clr_i,
  input  logic              src_en_we_i,
  input  logic              src_en_wd_i,
  input  logic              gie_we_i,
  input  logic              gie_wd_i,
  input  logic              sleep_i,
  input  logic              two_word_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              wake_o,
  output logic              dummy_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] ret_addr_o,
  output logic              flag_o,
  output logic              src_en_o,
  output logic              gie_o
);

  logic fall;
  logic take;

  pin_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .gate_i (osc_int_mode_i),
    .fall_o (fall)
  );

  irq_flag_regs i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_i   (fall),
    .clr_i    (flag_clr_i),
    .en_we_i  (src_en_we_i),
    .en_wd_i  (src_en_wd_i),
    .gie_we_i (gie_we_i),
    .gie_wd_i (gie_wd_i),
    .take_i   (take),
    .flag_o   (flag_o),
    .en_o     (src_en_o),
    .gie_o    (gie_o)
  );

  irq_vector_fsm #(
    .ADDR_W   (ADDR_W),
    .VEC_ADDR (VEC_ADDR)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .q1_i         (phase_q1_i),
    .sleep_i      (sleep_i),
    .flag_i       (flag_o),
    .en_i         (src_en_o),
    .gie_i        (gie_o),
    .two_word_i   (two_word_i),
    .pc_i         (pc_i),
    .take_o       (take),
    .wake_o       (wake_o),
    .dummy_o      (dummy_o),
    .vec_fetch_o  (vec_fetch_o),
    .fetch_addr_o (fetch_addr_o),
    .push_o       (push_o),
    .ret_addr_o   (ret_addr_o)
  );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_int_mode_i,
  input logic phase_q1_i,
  input logic flag_clr_i,
  input logic sleep_i,
  input logic wake_o,
  input logic dummy_o,
  input logic vec_fetch_o,
  input logic push_o,
  input logic flag_o
);

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(flag_clr_i));

  // R3
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(osc_int_mode_i));

  // R6
  strobe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dummy_o) |-> $past(phase_q1_i));

  // R7
  vec_after_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_fetch_o) |-> $past(dummy_o));

  // R7
  dummy_vec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dummy_o, vec_fetch_o}));

  // R8
  wake_in_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> $past(sleep_i));

  // R10
  push_first_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(push_o) |-> $rose(dummy_o));

endmodule

bind pin_irq_seq irq_seq_chk i_irq_seq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .osc_int_mode_i (osc_int_mode_i),
  .phase_q1_i     (phase_q1_i),
  .flag_clr_i     (flag_clr_i),
  .sleep_i        (sleep_i),
  .wake_o         (wake_o),
  .dummy_o        (dummy_o),
  .vec_fetch_o    (vec_fetch_o),
  .push_o         (push_o),
  .flag_o         (flag_o)
);

// File: tb/test_pin_irq_seq.sv
module test_pin_irq_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 13;
  localparam int PC_BASE    = 'h123;

  logic              clk;
  logic              rst_n;
  logic              pin_i, osc_int_mode_i, phase_q1_i, flag_clr_i;
  logic              src_en_we_i, src_en_wd_i, gie_we_i, gie_wd_i;
  logic              sleep_i, two_word_i;
  logic [ADDR_W-1:0] pc_i;
  logic              wake_o, dummy_o, vec_fetch_o, push_o;
  logic              flag_o, src_en_o, gie_o;
  logic [ADDR_W-1:0] fetch_addr_o, ret_addr_o;

  pin_irq_seq i_pin_irq_seq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .osc_int_mode_i(osc_int_mode_i),
    .phase_q1_i(phase_q1_i), .flag_clr_i(flag_clr_i),
    .src_en_we_i(src_en_we_i), .src_en_wd_i(src_en_wd_i),
    .gie_we_i(gie_we_i), .gie_wd_i(gie_wd_i), .sleep_i(sleep_i),
    .two_word_i(two_word_i), .pc_i(pc_i), .wake_o(wake_o), .dummy_o(dummy_o),
    .vec_fetch_o(vec_fetch_o), .fetch_addr_o(fetch_addr_o), .push_o(push_o),
    .ret_addr_o(ret_addr_o), .flag_o(flag_o), .src_en_o(src_en_o), .gie_o(gie_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // cyc advances at each falling edge; the next rising edge sees phase cyc%4.
  int cyc = 0;
  assign phase_q1_i = ((cyc % 4) == 0);

  typedef enum {F_WAKE, F_DUMMY, F_VEC, F_PUSH, F_FLAG, F_EN, F_GIE, F_FADDR, F_RADDR} fld_t;
  typedef struct {int at; fld_t fld; int val; string tag;} exp_t;
  exp_t sb[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic int observe(fld_t f);
    case (f)
      F_WAKE:  return int'(wake_o);
      F_DUMMY: return int'(dummy_o);
      F_VEC:   return int'(vec_fetch_o);
      F_PUSH:  return int'(push_o);
      F_FLAG:  return int'(flag_o);
      F_EN:    return int'(src_en_o);
      F_GIE:   return int'(gie_o);
      F_FADDR: return int'(fetch_addr_o);
      default: return int'(ret_addr_o);
    endcase
  endfunction

  // Monitor: compares every item due at this clock, then advances cyc.
  always @(negedge clk) begin
    int got;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at <= cyc) begin
        got = observe(sb[i].fld);
        n_cmp++;
        if (sb[i].at < cyc || got != sb[i].val) begin
          n_bad++;
          $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                   sb[i].tag, sb[i].fld.name(), sb[i].at, got, sb[i].val);
        end
        sb.delete(i);
      end
    end
    cyc++;
  end

  task automatic tick(int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic expect_at(int at, fld_t f, int v, string tag);
    sb.push_back('{at, f, v, tag});
  endtask

  task automatic drain();
    while (sb.size() > 0) tick(1);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) tick(1);
  endtask

  task automatic align(int ph);
    while ((cyc % 4) != ph) tick(1);
  endtask

  function automatic int next_q1(int f);
    int q = f + 1;
    while ((q % 4) != 0) q++;
    return q;
  endfunction

  // Pin goes low now; the flag is due on the third rising edge.
  task automatic drop_pin(output int f);
    pin_i = 1'b0;
    f = cyc + 3;
  endtask

  task automatic clear_flag(string tag);
    flag_clr_i = 1'b1;
    expect_at(cyc + 1, F_FLAG, 0, tag);
    tick(1);
    flag_clr_i = 1'b0;
  endtask

  task automatic set_en(bit v);
    src_en_we_i = 1'b1; src_en_wd_i = v; tick(1); src_en_we_i = 1'b0;
  endtask

  task automatic set_gie(bit v);
    gie_we_i = 1'b1; gie_wd_i = v; tick(1); gie_we_i = 1'b0;
  endtask

  task automatic restore_pin();
    pin_i = 1'b1;
    tick(6);
  endtask

  // Full vector sequence relative to the take clock q.
  task automatic exp_vector(int q, int ret, string tag);
    expect_at(q - 1,  F_GIE,   1,   tag);
    expect_at(q,      F_GIE,   0,   "R10");
    expect_at(q,      F_RADDR, ret, "R10");
    expect_at(q,      F_DUMMY, 0,   tag);
    expect_at(q + 3,  F_DUMMY, 0,   tag);
    expect_at(q + 4,  F_DUMMY, 1,   tag);
    expect_at(q + 4,  F_PUSH,  1,   "R10");
    expect_at(q + 7,  F_PUSH,  1,   "R10");
    expect_at(q + 8,  F_PUSH,  0,   "R10");
    expect_at(q + 11, F_DUMMY, 1,   tag);
    expect_at(q + 11, F_VEC,   0,   tag);
    expect_at(q + 12, F_VEC,   1,   tag);
    expect_at(q + 12, F_DUMMY, 0,   tag);
    expect_at(q + 12, F_FADDR, 4,   tag);
    expect_at(q + 16, F_FADDR, 5,   tag);
    expect_at(q + 19, F_VEC,   1,   tag);
    expect_at(q + 20, F_VEC,   0,   tag);
  endtask

  initial begin
    int f, q, q2;
    rst_n = 1'b0; pin_i = 1'b1; osc_int_mode_i = 1'b0; flag_clr_i = 1'b0;
    src_en_we_i = 1'b0; src_en_wd_i = 1'b0; gie_we_i = 1'b0; gie_wd_i = 1'b0;
    sleep_i = 1'b0; two_word_i = 1'b0; pc_i = ADDR_W'(PC_BASE);
    tick(3);
    rst_n = 1'b1;
    // R1: reset state
    expect_at(cyc + 1, F_FLAG,  0, "R1");
    expect_at(cyc + 1, F_EN,    0, "R1");
    expect_at(cyc + 1, F_GIE,   0, "R1");
    expect_at(cyc + 1, F_WAKE,  0, "R1");
    expect_at(cyc + 1, F_DUMMY, 0, "R1");
    expect_at(cyc + 1, F_VEC,   0, "R1");
    expect_at(cyc + 1, F_PUSH,  0, "R1");
    tick(4);

    // R3: mode low, falling edge ignored
    drop_pin(f);
    expect_at(f,     F_FLAG, 0, "R3");
    expect_at(f + 4, F_FLAG, 0, "R3");
    tick(6);
    restore_pin();
    osc_int_mode_i = 1'b1;
    tick(2);

    // R2 falling edge sets flag; R4 holds
    drop_pin(f);
    expect_at(f - 1,  F_FLAG, 0, "R2");
    expect_at(f,      F_FLAG, 1, "R2");
    expect_at(f + 12, F_FLAG, 1, "R4");
    drain();
    clear_flag("R4");
    pin_i = 1'b1;
    expect_at(cyc + 3, F_FLAG, 0, "R2");
    expect_at(cyc + 8, F_FLAG, 0, "R2");
    drain();

    // R4: clear and new edge in the same clock, edge wins
    drop_pin(f);
    tick(6);
    restore_pin();
    drop_pin(f);
    expect_at(f,     F_FLAG, 1, "R4");
    expect_at(f + 3, F_FLAG, 1, "R4");
    tick(2);
    flag_clr_i = 1'b1;
    tick(1);
    flag_clr_i = 1'b0;
    drain();
    clear_flag("R4");
    restore_pin();

    // R5: source enable off blocks the request
    set_gie(1'b1);
    drop_pin(f);
    q = next_q1(f);
    expect_at(f,      F_FLAG,  1, "R5");
    expect_at(q + 4,  F_DUMMY, 0, "R5");
    expect_at(q + 12, F_VEC,   0, "R5");
    expect_at(q + 12, F_GIE,   1, "R5");
    drain();
    clear_flag("R5");
    restore_pin();

    // R6 / R7: flag set just after a strobe, 3-cycle latency, one-word instruction
    set_en(1'b1);
    align(2);
    drop_pin(f);
    q = next_q1(f);
    expect_at(f + 1, F_GIE, 1, "R6");
    exp_vector(q, PC_BASE + 1, "R7");
    drain();
    clear_flag("R7");
    restore_pin();

    // R7 / R10: flag set on a strobe clock, two-word instruction
    two_word_i = 1'b1;
    set_gie(1'b1);
    align(1);
    drop_pin(f);
    q = next_q1(f);
    exp_vector(q, PC_BASE + 2, "R7");
    drain();
    clear_flag("R7");
    restore_pin();
    two_word_i = 1'b0;

    // R8 / R9: wake with global enable off, no vector afterwards
    set_gie(1'b0);
    sleep_i = 1'b1;
    tick(1);
    drop_pin(f);
    q = next_q1(f);
    expect_at(q - 1, F_WAKE,  0, "R8");
    expect_at(q,     F_WAKE,  1, "R8");
    expect_at(q + 4, F_WAKE,  1, "R8");
    expect_at(q + 4, F_DUMMY, 0, "R8");
    wait_until(q + 5);
    sleep_i = 1'b0;
    q2 = next_q1(q + 5);
    expect_at(q2,      F_WAKE,  0, "R8");
    expect_at(q2 + 4,  F_DUMMY, 0, "R9");
    expect_at(q2 + 12, F_VEC,   0, "R9");
    drain();
    clear_flag("R9");
    restore_pin();

    // R8: no wake with source enable off
    set_en(1'b0);
    set_gie(1'b1);
    sleep_i = 1'b1;
    tick(1);
    drop_pin(f);
    q = next_q1(f);
    expect_at(f,     F_FLAG, 1, "R8");
    expect_at(q,     F_WAKE, 0, "R8");
    expect_at(q + 4, F_WAKE, 0, "R8");
    drain();
    clear_flag("R8");
    restore_pin();
    sleep_i = 1'b0;
    tick(2);

    // R9: wake with global enable on, vector after sleep ends
    set_en(1'b1);
    sleep_i = 1'b1;
    tick(1);
    drop_pin(f);
    q = next_q1(f);
    expect_at(q,     F_WAKE,  1, "R9");
    expect_at(q + 4, F_DUMMY, 0, "R9");
    wait_until(q + 5);
    sleep_i = 1'b0;
    q2 = next_q1(q + 5);
    expect_at(q2, F_WAKE, 0, "R9");
    exp_vector(q2, PC_BASE + 1, "R9");
    drain();
    clear_flag("R9");
    tick(2);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule